// File: doc/BRIEF.md
# Limit-Aware Up/Down Pulse Counter Channel

This block is a single counting channel that steps a count up or down by one for each enabled count pulse, with the direction taken from a direction input. The counting range runs from zero to a programmable top value. At either end of that range the count either wraps around or stops, depending on two configuration bits. A stopped count stays put until the host clears the matching status flag.

Two status flags, limit and zero, tell the host when the count has reached an end of its range. A mode bit selects how the flags behave. In latched mode they stay set until the host clears them. In auto mode a host read strobe clears them, and they come back on the next cycle if the count still sits at that end. A count-size input selects 16-bit or 24-bit operation. A programmed limit of zero stands for the full count size, so the count register is one bit wider than the widest mode. A synchronous load can place any value in the count.

Top module: `updown_limit_counter`

## Requirements
- R1: After reset the count is 0, the limit flag is 0 and the zero flag is 1.
- R2: With `load` low, each cycle with `cnt_en` high and no stall moves the count by one: up when `cnt_dn` is 0, down when `cnt_dn` is 1.
- R3: With the matching hold bit at 0, an up pulse at the top value gives 0, and a down pulse at 0 gives the top value.
- R4: With `hold_top` at 1, up pulses that arrive while the count is at the top value and the limit flag is set are discarded. Once the flag is cleared, the next up pulse rolls the count to 0.
- R5: With `hold_bottom` at 1, down pulses that arrive while the count is 0 and the zero flag is set are discarded. Once the flag is cleared, the next down pulse wraps the count to the top value.
- R6: The top value is `limit_val` when that value is nonzero. In 16-bit mode (`wide_mode`=0) only `limit_val[15:0]` is used, and zero there means 65,536. In 24-bit mode (`wide_mode`=1) zero means 16,777,216.
- R7: A count step whose new value equals the top value sets the limit flag. A count step whose new value is 0 sets the zero flag.
- R8: In latched mode (`auto_clear`=0) the flags hold their value until `flag_clr` is pulsed, and `host_read` has no effect on them.
- R9: In auto mode (`auto_clear`=1) a `host_read` cycle clears both flags. On any cycle without `host_read`, a flag is set if the count is at its end of the range.
- R10: When a flag-setting step and a clear request fall in the same cycle, the flag ends up set.
- R11: `load` takes priority over a count pulse in the same cycle, places `load_val` in the count, and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0 selects 16-bit count size, 1 selects 24-bit |
| hold_top | input | 1 | Stop at the top value instead of rolling to 0 |
| hold_bottom | input | 1 | Stop at 0 instead of wrapping to the top value |
| auto_clear | input | 1 | 0 latches the flags, 1 clears them on each host read |
| limit_val | input | CW | Programmed limit; zero means full count size |
| load | input | 1 | Synchronous load strobe |
| load_val | input | CW+1 | Value placed in the count on load |
| cnt_en | input | 1 | Count pulse |
| cnt_dn | input | 1 | Direction: 1 counts down |
| flag_clr | input | 1 | Host flag-clear strobe |
| host_read | input | 1 | Marks one host read of the channel |
| count | output | CW+1 | Current count |
| limit_flag | output | 1 | Limit status flag |
| zero_flag | output | 1 | Zero status flag |

## Verification
The bench builds the counter with its default widths (CW=24, NW=16) and switches count size at run time through `wide_mode`. A small limit of 5 makes rollover, wrap, hold and release reachable in a few pulses. A zero limit brings both full-size tops, 65,536 and 16,777,216, into reach through loads placed just below them. A limit with upper bits set in 16-bit mode shows that those bits are ignored.

// File: rtl/updown_limit_counter.sv
module updown_limit_counter #(
  parameter int CW = 24,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          hold_top,
  input  logic          hold_bottom,
  input  logic          auto_clear,
  input  logic [CW-1:0] limit_val,
  input  logic          load,
  input  logic [CW:0]   load_val,
  input  logic          cnt_en,
  input  logic          cnt_dn,
  input  logic          flag_clr,
  input  logic          host_read,
  output logic [CW:0]   count,
  output logic          limit_flag,
  output logic          zero_flag
);
  localparam int TW = CW + 1;
  localparam logic [TW-1:0] FULL_WIDE   = TW'(1) << CW;
  localparam logic [TW-1:0] FULL_NARROW = TW'(1) << NW;

  logic [CW-1:0] lim_sel;
  logic [TW-1:0] top, nxt;
  logic up, dn, at_top, at_zero, stall, step, lim_set, zero_set, clr;

  assign lim_sel = wide_mode ? limit_val : CW'(limit_val[NW-1:0]);
  assign top     = (lim_sel == '0) ? (wide_mode ? FULL_WIDE : FULL_NARROW) : TW'(lim_sel);

  assign up      = cnt_en && !cnt_dn;
  assign dn      = cnt_en && cnt_dn;
  assign at_top  = (count >= top);
  assign at_zero = (count == '0);

  assign stall = (up && at_top  && hold_top    && limit_flag) ||
                 (dn && at_zero && hold_bottom && zero_flag);
  assign step  = cnt_en && !stall && !load;

  always_comb begin
    nxt = count;
    if (load)      nxt = load_val;
    else if (step) begin
      if (up) nxt = at_top  ? '0  : count + TW'(1);
      else    nxt = at_zero ? top : count - TW'(1);
    end
  end

  assign lim_set  = (step && nxt == top) || (auto_clear && !host_read && count == top);
  assign zero_set = (step && nxt == '0)  || (auto_clear && !host_read && at_zero);
  assign clr      = flag_clr || (auto_clear && host_read);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      limit_flag <= 1'b0;
      zero_flag  <= 1'b1;
    end else begin
      count <= nxt;
      if (lim_set)  limit_flag <= 1'b1;
      else if (clr) limit_flag <= 1'b0;
      if (zero_set) zero_flag  <= 1'b1;
      else if (clr) zero_flag  <= 1'b0;
    end
  end

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && up && count < top) |=> count == TW'($past(count) + TW'(1)));

  a_r3_roll_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && up && !hold_top && count == top) |=> count == '0);

  a_r4_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && up && hold_top && limit_flag && count == top) |=> $stable(count));

  a_r5_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dn && hold_bottom && zero_flag && count == '0) |=> $stable(count));

  a_r8_latched_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_clear && !flag_clr && limit_flag) |=> limit_flag);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && step && nxt == top) |=> limit_flag);
endmodule

// File: tb/tb_updown_limit_counter.sv
module tb_updown_limit_counter;
  localparam int CW = 24;
  localparam int NW = 16;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wide_mode = 0, hold_top = 0, hold_bottom = 0, auto_clear = 0;
  logic [CW-1:0] limit_val = 24'd5;
  logic load = 0, cnt_en = 0, cnt_dn = 0, flag_clr = 0, host_read = 0;
  logic [CW:0] load_val = '0;
  logic [CW:0] count;
  logic limit_flag, zero_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [CW:0] cnt;
    logic lim;
    logic zer;
    string tag;
  } item_t;
  item_t q[$];

  updown_limit_counter #(.CW(CW), .NW(NW)) dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .hold_top(hold_top),
    .hold_bottom(hold_bottom), .auto_clear(auto_clear), .limit_val(limit_val),
    .load(load), .load_val(load_val), .cnt_en(cnt_en), .cnt_dn(cnt_dn),
    .flag_clr(flag_clr), .host_read(host_read), .count(count),
    .limit_flag(limit_flag), .zero_flag(zero_flag));

  always #(PERIOD/2) clk = ~clk;

  task automatic compare(item_t e);
    checks++;
    if (count !== e.cnt || limit_flag !== e.lim || zero_flag !== e.zer) begin
      errors++;
      $display("FAIL %s: got count=%0d lim=%b zero=%b, expected count=%0d lim=%b zero=%b",
               e.tag, count, limit_flag, zero_flag, e.cnt, e.lim, e.zer);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic cyc(input logic en, input logic d, input logic ld, input logic [CW:0] lv,
                     input logic c, input logic rd, input logic [CW:0] ec,
                     input logic el, input logic ez, input string tag);
    item_t it;
    @(negedge clk);
    cnt_en = en; cnt_dn = d; load = ld; load_val = lv; flag_clr = c; host_read = rd;
    it.cnt = ec; it.lim = el; it.zer = ez; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle_cfg(input logic w, input logic ht, input logic hb,
                          input logic ac, input logic [CW-1:0] lim);
    @(negedge clk);
    cnt_en = 0; cnt_dn = 0; load = 0; flag_clr = 0; host_read = 0;
    wide_mode = w; hold_top = ht; hold_bottom = hb; auto_clear = ac; limit_val = lim;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    item_t r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    r.cnt = 0; r.lim = 0; r.zer = 1; r.tag = "R1 reset state";
    compare(r);

    cyc(0,0,0,0,1,0, 0,0,0, "R8 explicit clear");
    cyc(1,0,0,0,0,0, 1,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 2,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 3,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 4,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 5,1,0, "R7 reach top");
    cyc(0,0,0,0,0,1, 5,1,0, "R8 read ignored");
    cyc(1,0,0,0,0,0, 0,1,1, "R3 roll to zero");
    cyc(1,1,0,0,0,0, 5,1,1, "R3 wrap to top");
    cyc(0,0,0,0,1,0, 5,0,0, "R8 clear");

    idle_cfg(0,1,0,0,24'd5);
    cyc(1,0,1,4,0,0, 4,0,0, "R11 load beats pulse");
    cyc(1,0,0,0,0,0, 5,1,0, "R7 reach top");
    cyc(1,0,0,0,0,0, 5,1,0, "R4 held");
    cyc(1,0,0,0,0,0, 5,1,0, "R4 held");
    cyc(1,0,0,0,1,0, 5,0,0, "R4 clear discards pulse");
    cyc(1,0,0,0,0,0, 0,0,1, "R4 resume roll");

    idle_cfg(0,0,0,0,24'd5);
    cyc(1,1,0,0,1,0, 5,1,0, "R10 set beats clear");

    idle_cfg(0,0,1,0,24'd5);
    cyc(0,0,0,0,1,0, 5,0,0, "R8 clear");
    cyc(0,0,1,1,0,0, 1,0,0, "R11 load no flag");
    cyc(1,1,0,0,0,0, 0,0,1, "R7 reach zero");
    cyc(1,1,0,0,0,0, 0,0,1, "R5 held");
    cyc(0,0,0,0,1,0, 0,0,0, "R5 clear");
    cyc(1,1,0,0,0,0, 5,1,0, "R5 resume wrap");

    idle_cfg(0,0,1,1,24'd5);
    cyc(0,0,0,0,0,1, 5,0,0, "R9 read clears");
    cyc(0,0,0,0,0,0, 5,1,0, "R9 re-set at top");
    cyc(1,1,0,0,0,0, 4,1,0, "R9 stays");
    cyc(0,0,0,0,0,1, 4,0,0, "R9 read clears");
    cyc(0,0,0,0,0,0, 4,0,0, "R9 no re-set off end");

    idle_cfg(0,0,0,0,24'd0);
    cyc(0,0,1,65535,0,0, 65535,0,0, "R11 load");
    cyc(1,0,0,0,0,0, 65536,1,0, "R6 narrow full top");
    cyc(1,0,0,0,0,0, 0,1,1, "R6 narrow roll");
    cyc(1,1,0,0,0,0, 65536,1,1, "R6 narrow wrap");

    idle_cfg(1,0,0,0,24'd0);
    cyc(0,0,1,16777215,1,0, 16777215,0,0, "R6 wide load");
    cyc(1,0,0,0,0,0, 16777216,1,0, "R6 wide full top");

    idle_cfg(0,0,0,0,24'h010003);
    cyc(0,0,1,2,1,0, 2,0,0, "R6 load");
    cyc(1,0,0,0,0,0, 3,1,0, "R6 upper limit bits ignored");

    idle_cfg(0,0,0,0,24'h010003);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule